// File: doc/BRIEF.md
# EDO-Capable DRAM Read Controller

This block runs read cycles on one DRAM region. A request gives a start pulse, an address and a burst flag. The controller then sequences a multiplexed row and column address, an active-low row strobe and an active-low column strobe. It returns each captured word with a one-cycle valid pulse. A burst read keeps the row strobe low and steps through four consecutive columns in page mode.

A mode input selects how read data is captured. In fast-page mode the DRAM drives data only while the column strobe is low, so the word is taken on the falling clock edge in the middle of the strobe-low cycle. In extended-data-out mode the DRAM keeps the word on the bus after the column strobe rises, until the strobe falls again. The capture point therefore moves half a cycle later, to the rising edge that ends the strobe-low cycle. This gives the device half a clock more access time.

The extended mode applies only to addresses inside one designated region. Every other address uses fast-page timing.

Top module: `edo_dram_rd_ctrl`

## Requirements
- R1: While rst_ni is low, ras_no and cas_no are high and busy_o, rd_valid_o, done_o and latch_en_o are low.
- R2: After a request is accepted, the row address (addr_i bits [17:9]) is on dram_addr_o with ras_no high for one cycle. ras_no then falls with the row still presented. In the next cycle the column address (addr_i bits [8:0]) is presented with cas_no high, and in the cycle after that cas_no is low for exactly one cycle.
- R3: cas_no is never low while ras_no is high.
- R4: A single read (burst_i=0) returns one word: the DRAM word at the requested row and column. done_o is high 5 cycles after the accepting clock edge.
- R5: A burst read (burst_i=1) returns 4 words from columns col, col+1, col+2 and col+3, where the column wraps modulo 512. cas_no is high for one cycle between beats, ras_no stays low for the whole burst, and done_o is high 11 cycles after acceptance.
- R6: In fast-page mode the read word is sampled on the falling clock edge inside the cas_no-low cycle.
- R7: When edo_en_i is 1 at acceptance and the address lies in the extended region, the read word is sampled on the rising edge that ends the cas_no-low cycle.
- R8: The extended region is defined as addr_i bits [19:18] equal to 2'b11. Any other address uses fast-page capture, whatever the value of edo_en_i. The mode and address are latched at acceptance.
- R9: rd_valid_o is high for one cycle, in the cycle after each cas_no-low cycle. done_o is high for one cycle, in the cycle in which ras_no returns high.
- R10: busy_o is high from acceptance until the sequence ends. A req_i seen while busy_o is high is ignored and starts no later sequence.
- R11: latch_en_o is high exactly in the cycles in which cas_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| edo_en_i | input | 1 | Mode bit: 1 selects extended-data-out capture inside the region |
| req_i | input | 1 | Read request, accepted when idle |
| addr_i | input | 20 | {region[1:0], row[8:0], col[8:0]} |
| burst_i | input | 1 | 1 requests a 4-beat page burst |
| dram_addr_o | output | 9 | Multiplexed row/column address |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| latch_en_o | output | 1 | Read-data latch enable |
| dram_data_i | input | 16 | DRAM read data |
| rd_data_o | output | 16 | Captured read word |
| rd_valid_o | output | 1 | One-cycle pulse per captured word |
| done_o | output | 1 | One-cycle pulse as the row strobe is negated |
| busy_o | output | 1 | Sequence in progress |

## Verification
The hardest condition to reach is one where the two capture points actually return different words. With an ideal memory model both edges would sample the same value. The DRAM model in the bench therefore uses asymmetric windows. In page mode it shows the word only from 1 ns to 4 ns after the column strobe falls, so a rising-edge capture misses it. In extended mode it shows the word only from 3 ns after the strobe falls until the next fall, so a falling-edge capture misses it.

The random mix varies the region bits, the mode bit and the burst flag. It also changes edo_en_i and addr_i, and pulses req_i, while a sequence runs. Directed cases cover column wrap at 511 and a mode bit set outside the region.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_PRE,
    ST_END
  } rd_state_e;
endpackage

// File: rtl/edo_dram_seq.sv
module edo_dram_seq
  import edo_dram_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic burst_i,
  output logic accept_o,
  output logic col_inc_o,
  output logic sel_col_o,
  output logic ras_no,
  output logic cas_no,
  output logic latch_en_o,
  output logic done_o,
  output logic busy_o
);
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  rd_state_e      st_q, st_d;
  logic [BW-1:0]  beat_q;
  logic           burst_q;
  logic           last_beat;

  assign accept_o  = req_i && (st_q == ST_IDLE);
  assign last_beat = !burst_q || (beat_q == BW'(BURST_LEN - 1));
  assign col_inc_o = (st_q == ST_CAS) && !last_beat;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_ROW;
      ST_ROW:  st_d = ST_RAS;
      ST_RAS:  st_d = ST_COL;
      ST_COL:  st_d = ST_CAS;
      ST_CAS:  st_d = last_beat ? ST_END : ST_PRE;
      ST_PRE:  st_d = ST_CAS;
      ST_END:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept_o) begin
        beat_q  <= '0;
        burst_q <= burst_i;
      end else if (col_inc_o) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign ras_no     = !(st_q inside {ST_RAS, ST_COL, ST_CAS, ST_PRE});
  assign cas_no     = (st_q != ST_CAS);
  assign latch_en_o = (st_q == ST_CAS);
  assign sel_col_o  = st_q inside {ST_COL, ST_CAS, ST_PRE};
  assign done_o     = (st_q == ST_END);
  assign busy_o     = (st_q != ST_IDLE);

  a_r3_cas_inside_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);
  a_r9_done_at_ras_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(ras_no));
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r5_cas_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |=> cas_no);
endmodule

// File: rtl/edo_dram_addr.sv
module edo_dram_addr #(
  parameter int                ROW_W   = 9,
  parameter int                COL_W   = 9,
  parameter int                RGN_W   = 2,
  parameter logic [RGN_W-1:0]  EDO_RGN = '1,
  localparam int               AW      = RGN_W + ROW_W + COL_W,
  localparam int               MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            col_inc_i,
  input  logic            sel_col_i,
  input  logic            edo_en_i,
  input  logic [AW-1:0]   addr_i,
  output logic [MA_W-1:0] dram_addr_o,
  output logic            edo_sel_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             rgn_hit;

  assign rgn_hit = (addr_i[AW-1 -: RGN_W] == EDO_RGN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q     <= '0;
      col_q     <= '0;
      edo_sel_o <= 1'b0;
    end else if (accept_i) begin
      row_q     <= addr_i[COL_W +: ROW_W];
      col_q     <= addr_i[0 +: COL_W];
      edo_sel_o <= edo_en_i && rgn_hit;
    end else if (col_inc_i) begin
      col_q <= col_q + 1'b1;
    end
  end

  assign dram_addr_o = sel_col_i ? MA_W'(col_q) : MA_W'(row_q);

  a_r8_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(edo_sel_o));
  a_r2_row_at_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_col_i && $past(accept_i)) |=> (dram_addr_o == $past(dram_addr_o)));
endmodule

// File: rtl/edo_dram_cap.sv
module edo_dram_cap #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_en_i,
  input  logic          edo_sel_i,
  input  logic [DW-1:0] dram_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic [DW-1:0] cap_fall_q;
  logic [DW-1:0] cap_rise_q;

  // Page mode: data only valid mid-strobe, take it on the falling edge.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cap_fall_q <= '0;
    else if (latch_en_i) cap_fall_q <= dram_data_i;
  end

  // EDO: data held past strobe negation, take it half a cycle later.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_rise_q <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= latch_en_i;
      if (latch_en_i) cap_rise_q <= dram_data_i;
    end
  end

  assign rd_data_o = edo_sel_i ? cap_rise_q : cap_fall_q;

  a_r9_valid_after_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(latch_en_i));
  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

// File: rtl/edo_dram_rd_ctrl.sv
module edo_dram_rd_ctrl #(
  parameter int               ROW_W     = 9,
  parameter int               COL_W     = 9,
  parameter int               RGN_W     = 2,
  parameter logic [RGN_W-1:0] EDO_RGN   = '1,
  parameter int               DW        = 16,
  parameter int               BURST_LEN = 4,
  localparam int              AW        = RGN_W + ROW_W + COL_W,
  localparam int              MA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edo_en_i,
  input  logic            req_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            burst_i,
  output logic [MA_W-1:0] dram_addr_o,
  output logic            ras_no,
  output logic            cas_no,
  output logic            latch_en_o,
  input  logic [DW-1:0]   dram_data_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_valid_o,
  output logic            done_o,
  output logic            busy_o
);
  logic accept, col_inc, sel_col, edo_sel;

  edo_dram_seq #(.BURST_LEN(BURST_LEN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .burst_i    (burst_i),
    .accept_o   (accept),
    .col_inc_o  (col_inc),
    .sel_col_o  (sel_col),
    .ras_no     (ras_no),
    .cas_no     (cas_no),
    .latch_en_o (latch_en_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  edo_dram_addr #(
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .RGN_W   (RGN_W),
    .EDO_RGN (EDO_RGN)
  ) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .col_inc_i   (col_inc),
    .sel_col_i   (sel_col),
    .edo_en_i    (edo_en_i),
    .addr_i      (addr_i),
    .dram_addr_o (dram_addr_o),
    .edo_sel_o   (edo_sel)
  );

  edo_dram_cap #(.DW(DW)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_en_i  (latch_en_o),
    .edo_sel_i   (edo_sel),
    .dram_data_i (dram_data_i),
    .rd_data_o   (rd_data_o),
    .rd_valid_o  (rd_valid_o)
  );

  a_r11_latch_with_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_en_o |-> (!cas_no && !ras_no));
endmodule

// File: tb/edo_dram_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_dram_rd_ctrl_tb_top;
  localparam int ROW_W = 9, COL_W = 9, RGN_W = 2, DW = 16, BL = 4;
  localparam int AW = RGN_W + ROW_W + COL_W;
  localparam logic [DW-1:0] JUNK = 16'hDEAD;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic edo_en_i = 1'b0, req_i = 1'b0, burst_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [8:0] dram_addr_o;
  logic ras_no, cas_no, latch_en_o, rd_valid_o, done_o, busy_o;
  logic [DW-1:0] dram_data_i = JUNK;
  logic [DW-1:0] rd_data_o;

  int errors = 0, checks = 0;
  logic model_edo = 1'b0;
  logic [8:0] m_row = '0, m_col = '0;

  always #2.5 clk_i = ~clk_i;

  edo_dram_rd_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .edo_en_i(edo_en_i), .req_i(req_i),
    .addr_i(addr_i), .burst_i(burst_i), .dram_addr_o(dram_addr_o),
    .ras_no(ras_no), .cas_no(cas_no), .latch_en_o(latch_en_o),
    .dram_data_i(dram_data_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  function automatic logic [DW-1:0] mem_word(input logic [8:0] r, input logic [8:0] c);
    return {r, c[6:0]} ^ {c, r[6:0]} ^ 16'h3C5A;
  endfunction

  // DRAM model: page window 1..4 ns after CAS falls; EDO from 3 ns until next CAS fall
  always @(negedge ras_no) m_row = dram_addr_o;
  always @(negedge cas_no) begin
    m_col = dram_addr_o;
    dram_data_i = JUNK;
    if (model_edo) begin
      #3 dram_data_i = mem_word(m_row, m_col);
    end else begin
      #1 dram_data_i = mem_word(m_row, m_col);
      #3 dram_data_i = JUNK;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input logic b, input logic e);
    logic exp_edo;
    int nb, lat, beats, done_n;
    logic prev_ras;
    logic [8:0] row, col;
    exp_edo = e && (a[AW-1 -: RGN_W] == 2'b11);
    model_edo = exp_edo;
    nb = b ? BL : 1;
    lat = 3 + 2 * nb;
    row = a[COL_W +: ROW_W];
    col = a[8:0];
    beats = 0; done_n = 0; prev_ras = 1'b1;
    req_i = 1'b1; addr_i = a; burst_i = b; edo_en_i = e;
    for (int n = 1; n <= lat + 2; n++) begin
      @(posedge clk_i); #1;
      case (n)
        1: begin
          chk(busy_o && ras_no && dram_addr_o == row, "R2 row phase", {ras_no, dram_addr_o}, {1'b1, row});
          chk(busy_o, "R10 busy", busy_o, 1);
          req_i = 1'b0; addr_i = AW'($urandom); edo_en_i = 1'($urandom);
          burst_i = 1'($urandom);
        end
        2: begin
          chk(!ras_no && dram_addr_o == row, "R2 ras fall", {ras_no, dram_addr_o}, {1'b0, row});
          req_i = 1'b1; addr_i = AW'($urandom);
        end
        3: begin
          chk(cas_no && dram_addr_o == col, "R2 col phase", {cas_no, dram_addr_o}, {1'b1, col});
          req_i = 1'b0;
        end
        4: chk(!cas_no, "R2 cas low", cas_no, 0);
        default: ;
      endcase
      chk(!(!cas_no && ras_no), "R3 cas inside ras", {ras_no, cas_no}, 2'b00);
      chk(latch_en_o == !cas_no, "R11 latch", latch_en_o, !cas_no);
      if (rd_valid_o) begin
        logic [DW-1:0] exp_d;
        exp_d = mem_word(row, col + 9'(beats));
        chk(rd_data_o == exp_d, exp_edo ? (b ? "R7 R5 edo burst data" : "R7 R4 edo data")
                                        : (b ? "R6 R5 page burst data" : "R6 R4 page data"),
            rd_data_o, exp_d);
        beats++;
      end
      if (done_o) begin
        done_n = n;
        chk(ras_no && !prev_ras, "R9 done at ras rise", {prev_ras, ras_no}, 2'b01);
      end
      if (b && n > 4 && n < lat) chk(!ras_no, "R5 ras held", ras_no, 0);
      prev_ras = ras_no;
    end
    chk(done_n == lat, b ? "R5 done latency" : "R4 done latency", done_n, lat);
    chk(beats == nb, b ? "R5 beat count" : "R4 beat count", beats, nb);
    chk(!busy_o && ras_no, "R10 ignored req", {busy_o, ras_no}, 2'b01);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk(ras_no && cas_no && !busy_o && !rd_valid_o && !done_o && !latch_en_o,
        "R1 reset", {ras_no, cas_no, busy_o, rd_valid_o, done_o, latch_en_o}, 6'b110000);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // directed: single page, single EDO, wrap at 511, mode bit outside region
    run_txn({2'b00, 9'd17, 9'd5}, 1'b0, 1'b0);
    run_txn({2'b11, 9'd300, 9'd42}, 1'b0, 1'b1);
    run_txn({2'b11, 9'd88, 9'd510}, 1'b1, 1'b1);
    run_txn({2'b01, 9'd77, 9'd511}, 1'b1, 1'b1);
    run_txn({2'b11, 9'd12, 9'd3}, 1'b1, 1'b0);
    for (int i = 0; i < 40; i++)
      run_txn(AW'($urandom), 1'($urandom), 1'($urandom));
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule